// File: doc/BRIEF.md
# ECC Error Status and Counter Registers

This block gathers error events from the ECC decoders of two memory banks and presents them to software as a small 32-bit register file. Each bank reports two kinds of events: a corrected single-bit error and a detected, uncorrectable double-bit error. For every bank and event type the block keeps a sticky status flag and a 16-bit saturating event counter. Software can mask the status update for each event type. It clears status flags by writing 1 to them, and it zeroes counters through a register whose bits act as one-cycle pulses.

A control register gives each bank an ECC-enable output and a soft-reset output, both wired back to that bank's ECC logic. While a bank's soft-reset bit is held, its counters stay at zero. The register port is a plain address/data interface with separate write and read strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `ecc_err_regs`

## Requirements
- R1: When a bank's single-bit or double-bit event input is high at a clock edge and the matching update-enable bit is 1, the matching status bit becomes 1 at that edge and stays 1 until software clears it.
- R2: The status register sits at word offset 0x08. Bank b uses bit 2b for single-bit errors and bit 2b+1 for double-bit errors. Writing 1 to a bit clears only that bit, and writing 0 leaves the bit as it was.
- R3: If a write-1 clear and a new enabled event reach the same status bit in the same cycle, the bit stays 1.
- R4: The update-enable register (offset 0x04, read/write) uses the same bit layout as the status register. When a bit is 0, the matching status bit is not set by events. The counters still count those events.
- R5: Bank b has a counter word at offset 0x10+4b. The double-bit count is in bits 31:16 and the single-bit count is in bits 15:0. Each counter goes up by one for every clock edge at which its event input is high.
- R6: A counter that has reached 0xFFFF stays at 0xFFFF when more events arrive.
- R7: The counter-clear register is at offset 0x0C and uses the status bit layout. Writing 1 to a bit zeroes the matching counter at the following clock edge. An event in that same cycle is lost, because the clear wins. Reading this register returns 0.
- R8: The control register is at offset 0x00 and is read/write. Bank b's bit 2b drives ecc_en[b] and bit 2b+1 drives soft_rst[b]. While soft_rst[b] is 1, both of bank b's counters are held at zero.
- R9: After reset, every register reads 0 and both output vectors are 0. rd_data is loaded at the clock edge where rd_en is high. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| addr | input | ADDR_W (8) | Byte address; the two low bits are ignored |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| sb_err | input | NUM_BANKS (2) | Per-bank single-bit corrected error event |
| db_err | input | NUM_BANKS (2) | Per-bank double-bit detected error event |
| ecc_en | output | NUM_BANKS (2) | Per-bank ECC enable |
| soft_rst | output | NUM_BANKS (2) | Per-bank ECC soft reset |

## Verification
Two pairs of actions can land on the same state in one cycle.

The first pair is a software write-1 clear and a hardware event on the same status bit. The bench provokes it by raising a double-bit event in the exact cycle of a status write that targets that bit. It then judges the result by reading back the status word, where the bit must still be set.

The second pair is a counter-clear pulse and an event on the same counter. The bench raises the event in the cycle after the clear write, which is the cycle the pulse is live. A later read must show zero.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;
    localparam int REG_W        = 32;
    localparam int OFF_CTRL     = 'h00;
    localparam int OFF_UPD_EN   = 'h04;
    localparam int OFF_STATUS   = 'h08;
    localparam int OFF_CNT_CLR  = 'h0C;
    localparam int OFF_CNT_BASE = 'h10;
endpackage

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != {W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ecc_bank_track.sv
module ecc_bank_track #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sb_ev,
    input  logic             db_ev,
    input  logic [1:0]       upd_en,
    input  logic [1:0]       w1c,
    input  logic [1:0]       cnt_clr,
    input  logic             hold_zero,
    output logic [1:0]       status,
    output logic [CNT_W-1:0] sb_cnt,
    output logic [CNT_W-1:0] db_cnt
);
    logic [1:0] status_d, status_q;
    logic [1:0] ev;

    assign ev = {db_ev, sb_ev};

    // new events win over a simultaneous write-1 clear
    always_comb begin
        status_d = (status_q & ~w1c) | (ev & upd_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status = status_q;

    ecc_sat_counter #(.W(CNT_W)) u_sb_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr[0] | hold_zero),
        .inc   (sb_ev),
        .cnt   (sb_cnt)
    );

    ecc_sat_counter #(.W(CNT_W)) u_db_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr[1] | hold_zero),
        .inc   (db_ev),
        .cnt   (db_cnt)
    );
endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
    import ecc_regs_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 rd_en,
    output logic [REG_W-1:0]     rd_data,
    input  logic [NUM_BANKS-1:0] sb_err,
    input  logic [NUM_BANKS-1:0] db_err,
    output logic [NUM_BANKS-1:0] ecc_en,
    output logic [NUM_BANKS-1:0] soft_rst
);
    localparam int FW = 2 * NUM_BANKS;
    localparam int WW = ADDR_W - 2;

    typedef struct packed {
        logic [FW-1:0]    ctrl;
        logic [FW-1:0]    upd_en;
        logic [FW-1:0]    clr_pls;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [WW-1:0]                   word;
    logic                            hit_ctrl, hit_upd, hit_stat, hit_clr;
    logic [FW-1:0]                   w1c;
    logic [FW-1:0]                   status_q;
    logic [FW-1:0]                   upd_en_q;
    logic [FW-1:0]                   clr_pls_q;
    logic [NUM_BANKS-1:0][CNT_W-1:0] sb_cnt;
    logic [NUM_BANKS-1:0][CNT_W-1:0] db_cnt;
    logic [REG_W-1:0]                rd_mux;

    assign word     = addr[ADDR_W-1:2];
    assign hit_ctrl = (word == WW'(OFF_CTRL    >> 2));
    assign hit_upd  = (word == WW'(OFF_UPD_EN  >> 2));
    assign hit_stat = (word == WW'(OFF_STATUS  >> 2));
    assign hit_clr  = (word == WW'(OFF_CNT_CLR >> 2));
    assign w1c      = (wr_en && hit_stat) ? wr_data[FW-1:0] : '0;

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) rd_mux = REG_W'(regs_q.ctrl);
        if (hit_upd)  rd_mux = REG_W'(regs_q.upd_en);
        if (hit_stat) rd_mux = REG_W'(status_q);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (word == WW'((OFF_CNT_BASE >> 2) + b)) begin
                rd_mux = (REG_W'(db_cnt[b]) << 16) | REG_W'(sb_cnt[b]);
            end
        end
    end

    always_comb begin
        regs_d         = regs_q;
        regs_d.clr_pls = '0;
        if (wr_en && hit_ctrl) regs_d.ctrl    = wr_data[FW-1:0];
        if (wr_en && hit_upd)  regs_d.upd_en  = wr_data[FW-1:0];
        if (wr_en && hit_clr)  regs_d.clr_pls = wr_data[FW-1:0];
        if (rd_en)             regs_d.rdata   = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign upd_en_q  = regs_q.upd_en;
    assign clr_pls_q = regs_q.clr_pls;
    assign rd_data   = regs_q.rdata;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign ecc_en[b]   = regs_q.ctrl[2*b];
        assign soft_rst[b] = regs_q.ctrl[2*b+1];

        ecc_bank_track #(.CNT_W(CNT_W)) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .sb_ev     (sb_err[b]),
            .db_ev     (db_err[b]),
            .upd_en    (regs_q.upd_en[2*b+1:2*b]),
            .w1c       (w1c[2*b+1:2*b]),
            .cnt_clr   (regs_q.clr_pls[2*b+1:2*b]),
            .hold_zero (regs_q.ctrl[2*b+1]),
            .status    (status_q[2*b+1:2*b]),
            .sb_cnt    (sb_cnt[b]),
            .db_cnt    (db_cnt[b])
        );
    end
endmodule

// File: rtl/ecc_err_regs_chk.sv
module ecc_err_regs_chk
    import ecc_regs_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [ADDR_W-1:0]               addr,
    input logic                            wr_en,
    input logic [REG_W-1:0]                wr_data,
    input logic                            rd_en,
    input logic [REG_W-1:0]                rd_data,
    input logic [NUM_BANKS-1:0]            sb_err,
    input logic [NUM_BANKS-1:0]            soft_rst,
    input logic [2*NUM_BANKS-1:0]          upd_en_q,
    input logic [2*NUM_BANKS-1:0]          status_q,
    input logic [2*NUM_BANKS-1:0]          clr_pls_q,
    input logic [NUM_BANKS-1:0][CNT_W-1:0] sb_cnt,
    input logic [NUM_BANKS-1:0][CNT_W-1:0] db_cnt
);
    localparam int WW = ADDR_W - 2;
    logic [WW-1:0] word;
    assign word = addr[ADDR_W-1:2];

    for (genvar i = 0; i < 2*NUM_BANKS; i++) begin : g_bit
        // R2
        status_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status_q[i]) |-> $past(wr_en && (word == WW'(OFF_STATUS >> 2)) && wr_data[i]));
        // R4
        status_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[i]) |-> $past(upd_en_q[i]));
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
        // R1
        status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(sb_err[b] && upd_en_q[2*b]) |-> status_q[2*b]);
        // R6
        sb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sb_cnt[b] != $past(sb_cnt[b])) |->
            ((sb_cnt[b] == CNT_W'($past(sb_cnt[b]) + 1'b1)) || (sb_cnt[b] == '0)));
        // R6
        db_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (db_cnt[b] != $past(db_cnt[b])) |->
            ((db_cnt[b] == CNT_W'($past(db_cnt[b]) + 1'b1)) || (db_cnt[b] == '0)));
        // R8
        soft_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(soft_rst[b]) |-> ((sb_cnt[b] == '0) && (db_cnt[b] == '0)));
    end

    // R7
    clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_pls_q) |-> $past(wr_en && (word == WW'(OFF_CNT_CLR >> 2))));
    // R7
    clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (word == WW'(OFF_CNT_CLR >> 2))) |-> (rd_data == '0));
endmodule

bind ecc_err_regs ecc_err_regs_chk #(
    .NUM_BANKS (NUM_BANKS),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .sb_err    (sb_err),
    .soft_rst  (soft_rst),
    .upd_en_q  (upd_en_q),
    .status_q  (status_q),
    .clr_pls_q (clr_pls_q),
    .sb_cnt    (sb_cnt),
    .db_cnt    (db_cnt)
);

// File: tb/ecc_err_regs_tb.sv
module ecc_err_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [1:0]  sb_err = '0;
    logic [1:0]  db_err = '0;
    logic [1:0]  ecc_en;
    logic [1:0]  soft_rst;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    logic rd_pend = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_err_regs u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .sb_err   (sb_err),
        .db_err   (db_err),
        .ecc_en   (ecc_en),
        .soft_rst (soft_rst)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // monitor: compares registered read data one half cycle after the capture edge
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check(rd_data, 32'hDEAD_BEEF, "unexpected read");
            end else begin
                check(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ev(input logic [7:0] a, input logic [31:0] d,
                         input logic [1:0] s, input logic [1:0] m);
        addr = a; wr_data = d; wr_en = 1'b1; sb_err = s; db_err = m;
        @(negedge clk);
        wr_en = 1'b0; sb_err = '0; db_err = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ev(input logic [1:0] s, input logic [1:0] m);
        sb_err = s; db_err = m;
        @(negedge clk);
        sb_err = '0; db_err = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R9 reset state
        check(32'(ecc_en), 32'h0, "R9 ecc_en after reset");
        check(32'(soft_rst), 32'h0, "R9 soft_rst after reset");
        rd(8'h00, 32'h0, "R9 ctrl reset");
        rd(8'h04, 32'h0, "R9 upd_en reset");
        rd(8'h08, 32'h0, "R9 status reset");
        rd(8'h10, 32'h0, "R9 bank0 counters reset");
        rd(8'h14, 32'h0, "R9 bank1 counters reset");

        // R8 control register drives outputs
        wr(8'h00, 32'h5);
        rd(8'h00, 32'h5, "R8 ctrl readback");
        check(32'(ecc_en), 32'h3, "R8 ecc_en");
        check(32'(soft_rst), 32'h0, "R8 soft_rst clear");

        // R4 disabled update: status unchanged, counter still counts
        ev(2'b01, 2'b00);
        rd(8'h08, 32'h0, "R4 status gated");
        rd(8'h10, 32'h1, "R4 counter counts while gated");

        // R1 / R5 enabled events
        wr(8'h04, 32'hF);
        rd(8'h04, 32'hF, "R4 upd_en readback");
        ev(2'b01, 2'b10);
        rd(8'h08, 32'h9, "R1 status set");
        rd(8'h10, 32'h0000_0002, "R5 bank0 single count");
        rd(8'h14, 32'h0001_0000, "R5 bank1 double count");

        // R2 write-1 clear, write-0 keeps
        wr(8'h08, 32'h1);
        rd(8'h08, 32'h8, "R2 w1c bit0");
        wr(8'h08, 32'h0);
        rd(8'h08, 32'h8, "R2 write zero keeps");

        // R3 clear and event on the same bit in one cycle
        wr_ev(8'h08, 32'h8, 2'b00, 2'b10);
        rd(8'h08, 32'h8, "R3 event beats w1c");
        rd(8'h14, 32'h0002_0000, "R5 bank1 double count 2");

        // R7 counter clear pulse
        wr(8'h0C, 32'h1);
        idle(1);
        rd(8'h10, 32'h0, "R7 bank0 single cleared");
        rd(8'h14, 32'h0002_0000, "R7 other counter untouched");
        rd(8'h0C, 32'h0, "R7 clear reg reads zero");

        // R7 clear beats an event in the pulse cycle
        wr(8'h0C, 32'h8);
        ev(2'b00, 2'b10);
        rd(8'h14, 32'h0, "R7 clear beats event");

        // R6 saturation
        sb_err = 2'b10;
        idle(65540);
        sb_err = 2'b00;
        rd(8'h14, 32'h0000_FFFF, "R6 saturate");
        ev(2'b10, 2'b00);
        rd(8'h14, 32'h0000_FFFF, "R6 stays saturated");
        rd(8'h08, 32'hC, "R1 status bank1 single");

        // R8 soft reset holds counters at zero
        ev(2'b01, 2'b00);
        rd(8'h10, 32'h1, "R5 bank0 single after clear");
        wr(8'h00, 32'hD);
        idle(1);
        check(32'(soft_rst), 32'h2, "R8 soft_rst bank1");
        check(32'(ecc_en), 32'h3, "R8 ecc_en kept");
        rd(8'h14, 32'h0, "R8 soft reset zeroes");
        ev(2'b10, 2'b10);
        rd(8'h14, 32'h0, "R8 soft reset holds");
        rd(8'h10, 32'h1, "R8 other bank untouched");
        wr(8'h00, 32'h5);
        ev(2'b10, 2'b00);
        rd(8'h14, 32'h1, "R8 counting resumes");

        // R9 unmapped offset
        rd(8'h20, 32'h0, "R9 unmapped read");
        idle(2);
        summary();
    end
endmodule